// File: doc/BRIEF.md
# Read Data Output Stage with Selectable Latency

This block is the read-return path of a synchronous burst memory. Every clock cycle the cycle controller hands it a command class (read, write or deselect) together with the word read from the array. The block aligns that word to the chosen read latency and produces a data bus plus a single drive-enable flag. The flag stands in for the tri-state pad drivers, and it switches all byte lanes together.

A mode input chooses the latency for each cycle. In flow-through mode the word appears after one clock edge. In registered mode it passes through a second rising-edge register and appears after two. Non-read slots (writes and deselects) go through the same pipeline as reads, so in registered mode the drivers stay on for one more cycle after a deselect is accepted. An asynchronous output-enable input (active low) and a sleep input gate the drivers without waiting for a clock edge. Sleep also empties the pipeline of pending reads, and the data registers keep their values while it is asserted. When the mode pin is left unused, the `MODE_PIN_USED` and `STRAP_PIPE` parameters fix the stage in registered mode.

Top module: `rd_out_stage`

## Requirements
- R1: While reset is asserted and after it is released, `dq_oe_o` is 0 and `dq_o` is all zeros until a read passes through.
- R2: With `pipe_sel_i`=0 (flow-through), a read command (`cmd_i`=2'b01) together with its `rd_data_i` word appears on `dq_o` with `dq_oe_o`=1 after the first rising edge that samples it.
- R3: With `pipe_sel_i`=1 (registered), the same read appears after the second rising edge, and not after the first.
- R4: Back-to-back reads stream one word per cycle in both modes, so a four-beat burst completes 2-1-1-1 (flow-through) or 3-1-1-1 (registered) cycles after the controller's address edge.
- R5: A deselect (`cmd_i`=2'b00 or 2'b11) is pipelined to the same depth as a read. In registered mode the drivers remain on for the cycle after the deselect is sampled and turn off after the second edge.
- R6: A write slot (`cmd_i`=2'b10) never drives, whatever its position in the pipeline.
- R7: `oe_n_i`=1 turns `dq_oe_o` off in the same cycle, with no clock edge. Lowering it enables the drivers only if the slot currently at the output is a read.
- R8: A read taken while `oe_n_i`=1 (dummy read) still advances the pipeline and updates `dq_o`. A write may then follow with no deselect in between.
- R9: `sleep_i`=1 turns `dq_oe_o` off at once. Every edge taken in sleep discards pending reads and leaves `dq_o` unchanged. After wake-up the drivers stay off until a new read reaches the output.
- R10: `pipe_sel_i` may change between cycles. The output then follows the stage that the mode selects, with no reset needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 2 | Command class: 01 read, 10 write, 00/11 deselect |
| rd_data_i | input | DW (32) | Array read word, valid with a read command |
| pipe_sel_i | input | 1 | 1 registered latency, 0 flow-through |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Standby request, active high |
| dq_o | output | DW (32) | Read data bus |
| dq_oe_o | output | 1 | Drive enable for all byte lanes |

## Verification
Single isolated reads in each mode separate the one-edge latency from the two-edge latency. Four-beat bursts followed by a deselect show gap-free streaming and also show that turn-off is delayed by the pipeline. Read-then-write sequences run with the output enable held high show that dummy reads advance the pipeline while writes never drive. Sleep asserted in the middle of a burst, and the mode flipped during a stream, show that pending reads are discarded, that data is held through sleep, and that the mode selects the stage combinationally.

// File: rtl/rd_out_stage.sv
module rd_out_stage #(
  parameter int DW            = 32,
  parameter bit MODE_PIN_USED = 1'b1,
  parameter bit STRAP_PIPE    = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cmd_i,
  input  logic [DW-1:0] rd_data_i,
  input  logic          pipe_sel_i,
  input  logic          oe_n_i,
  input  logic          sleep_i,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o
);

  localparam logic [1:0] CMD_RD = 2'b01;
  localparam logic [1:0] CMD_WR = 2'b10;

  logic          pipe_mode;
  logic          s1_rd, s2_rd;
  logic [DW-1:0] s1_dat, s2_dat;

  generate
    if (MODE_PIN_USED) begin : g_pin
      assign pipe_mode = pipe_sel_i;
    end else begin : g_strap
      assign pipe_mode = STRAP_PIPE;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_rd  <= 1'b0;
      s2_rd  <= 1'b0;
      s1_dat <= '0;
      s2_dat <= '0;
    end else if (sleep_i) begin
      s1_rd  <= 1'b0;
      s2_rd  <= 1'b0;
    end else begin
      s1_rd  <= (cmd_i == CMD_RD);
      s2_rd  <= s1_rd;
      s2_dat <= s1_dat;
      if (cmd_i == CMD_RD) s1_dat <= rd_data_i;
    end
  end

  assign dq_o    = pipe_mode ? s2_dat : s1_dat;
  assign dq_oe_o = (pipe_mode ? s2_rd : s1_rd) & ~oe_n_i & ~sleep_i;

  logic [1:0] live;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= 2'd0;
    else if (live != 2'd3) live <= live + 2'd1;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) (live == 2'd0 && rst_n) |-> (!dq_oe_o && dq_o == '0)); // R1

  AST_FT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (live >= 2'd1 && !pipe_mode && !oe_n_i && !sleep_i && $past(cmd_i) == CMD_RD && !$past(sleep_i))
    |-> (dq_oe_o && dq_o == $past(rd_data_i))); // R2

  AST_PP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (live >= 2'd2 && pipe_mode && !oe_n_i && !sleep_i && $past(cmd_i, 2) == CMD_RD
     && !$past(sleep_i, 1) && !$past(sleep_i, 2))
    |-> (dq_oe_o && dq_o == $past(rd_data_i, 2))); // R3

  AST_PP_DESEL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (live >= 2'd2 && pipe_mode && $past(cmd_i, 2) != CMD_RD) |-> !dq_oe_o); // R5

  AST_WR_SLOT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (live >= 2'd1 && !pipe_mode && $past(cmd_i) == CMD_WR) |-> !dq_oe_o); // R6

  AST_OE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n_i |-> !dq_oe_o); // R7

  AST_SLEEP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (live >= 2'd1 && $past(sleep_i)) |-> !dq_oe_o); // R9

  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (live >= 2'd1 && $past(sleep_i) && $stable(pipe_mode)) |-> $stable(dq_o)); // R9

endmodule

// File: tb/sim_rd_out_stage.sv
module sim_rd_out_stage;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] DS = 2'b00, RD = 2'b01, WR = 2'b10, D3 = 2'b11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cmd = DS;
  logic [31:0] din = '0;
  logic        psel = 1'b1;
  logic        oe_n = 1'b0;
  logic        slp = 1'b0;
  logic [31:0] dq;
  logic        dq_oe;

  int vectors = 0;
  int errors  = 0;

  bit          q_rd[$];
  logic [31:0] q_dat[$];

  rd_out_stage u0 (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .rd_data_i(din),
    .pipe_sel_i(psel), .oe_n_i(oe_n), .sleep_i(slp),
    .dq_o(dq), .dq_oe_o(dq_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference: one queue entry per accepted non-sleep edge; newest at the back.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_rd  = '{1'b0, 1'b0};
      q_dat = '{32'h0, 32'h0};
    end else if (slp) begin
      foreach (q_rd[i]) q_rd[i] = 1'b0;
    end else begin
      q_rd.push_back(cmd == RD);
      q_dat.push_back(cmd == RD ? din : q_dat[$]);
      void'(q_rd.pop_front());
      void'(q_dat.pop_front());
    end
  end

  task automatic check(input string tag);
    bit          e_rd;
    logic [31:0] e_dat;
    bit          e_oe;
    e_rd  = psel ? q_rd[0]  : q_rd[1];
    e_dat = psel ? q_dat[0] : q_dat[1];
    e_oe  = e_rd && !oe_n && !slp;
    vectors++;
    if (dq_oe !== e_oe || dq !== e_dat) begin
      errors++;
      $display("FAIL %s t=%0t: oe=%0b dq=%h expected oe=%0b dq=%h",
               tag, $time, dq_oe, dq, e_oe, e_dat);
    end
  endtask

  task automatic step(input logic [1:0] c, input logic [31:0] d, input logic o,
                      input logic s, input logic m, input string tag);
    @(negedge clk);
    cmd = c; din = d; oe_n = o; slp = s; psel = m;
    #1;
    check(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    // R1 reset
    repeat (2) begin @(negedge clk); #1; check("R1"); end
    @(negedge clk); rst_n = 1'b1; #1; check("R1");
    step(DS, 32'h0, 0, 0, 1, "R1");
    step(DS, 32'h0, 0, 0, 0, "R1");

    // R2 flow-through single read
    step(RD, 32'hA000_0001, 0, 0, 0, "R2");
    step(DS, 32'hFFFF_FFFF, 0, 0, 0, "R2");
    step(DS, 32'h0, 0, 0, 0, "R2");
    step(D3, 32'h0, 0, 0, 0, "R2");

    // R3 registered single read
    step(RD, 32'hB000_0002, 0, 0, 1, "R3");
    step(DS, 32'h0, 0, 0, 1, "R3");
    step(DS, 32'h0, 0, 0, 1, "R3");
    step(DS, 32'h0, 0, 0, 1, "R3");

    // R4 bursts of four, both modes; R5 delayed turn-off
    for (int i = 0; i < 4; i++) step(RD, 32'hC100_0000 + i, 0, 0, 0, "R4");
    step(DS, 32'h0, 0, 0, 0, "R4");
    step(DS, 32'h0, 0, 0, 0, "R4");
    for (int i = 0; i < 4; i++) step(RD, 32'hC200_0000 + i, 0, 0, 1, "R4");
    step(DS, 32'h0, 0, 0, 1, "R5");
    step(D3, 32'h0, 0, 0, 1, "R5");
    step(DS, 32'h0, 0, 0, 1, "R5");

    // R6 writes never drive, interleaved with reads
    for (int m = 0; m < 2; m++) begin
      step(RD, 32'hD000_0010 + m, 0, 0, m[0], "R6");
      step(WR, 32'hDEAD_BEEF, 0, 0, m[0], "R6");
      step(RD, 32'hD000_0020 + m, 0, 0, m[0], "R6");
      step(WR, 32'h1234_5678, 0, 0, m[0], "R6");
      step(WR, 32'h0, 0, 0, m[0], "R6");
      step(DS, 32'h0, 0, 0, m[0], "R6");
    end

    // R7/R8 dummy read with oe high, then write, then oe toggles
    step(RD, 32'hE000_0001, 1, 0, 1, "R8");
    step(WR, 32'h0, 1, 0, 1, "R8");
    step(WR, 32'h0, 1, 0, 1, "R8");
    step(RD, 32'hE000_0002, 0, 0, 1, "R7");
    step(RD, 32'hE000_0003, 0, 0, 1, "R7");
    step(RD, 32'hE000_0004, 1, 0, 1, "R7");
    step(DS, 32'h0, 0, 0, 1, "R7");
    step(DS, 32'h0, 1, 0, 1, "R7");
    step(DS, 32'h0, 0, 0, 1, "R7");
    step(DS, 32'h0, 0, 0, 1, "R7");

    // R9 sleep mid-burst, data held, off after wake
    for (int m = 0; m < 2; m++) begin
      step(RD, 32'hF000_0001 + m, 0, 0, m[0], "R9");
      step(RD, 32'hF000_0011 + m, 0, 0, m[0], "R9");
      step(RD, 32'h5555_5555, 0, 1, m[0], "R9");
      step(RD, 32'hAAAA_AAAA, 0, 1, m[0], "R9");
      step(DS, 32'h0, 0, 0, m[0], "R9");
      step(DS, 32'h0, 0, 0, m[0], "R9");
      step(RD, 32'hF000_0021 + m, 0, 0, m[0], "R9");
      step(DS, 32'h0, 0, 0, m[0], "R9");
      step(DS, 32'h0, 0, 0, m[0], "R9");
    end

    // R10 mode flipped during a stream
    for (int i = 0; i < 8; i++) step(RD, 32'h7000_0000 + i, 0, 0, i[0], "R10");
    for (int i = 0; i < 4; i++) step(i[1] ? WR : RD, 32'h7100_0000 + i, 0, 0, ~i[0], "R10");
    step(DS, 32'h0, 0, 0, 0, "R10");
    step(DS, 32'h0, 0, 0, 1, "R10");
    step(DS, 32'h0, 0, 0, 1, "R10");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule